// File: doc/BRIEF.md
# Breakpoint Acknowledge Controller

This block sits between instruction decode and the bus interface. It handles the opcodes set aside as software breakpoints. When decode presents a breakpoint opcode that has not already been substituted, the block stalls decode. It then issues one read cycle in the CPU address space, and the address of that read carries the breakpoint number. The block waits for the cycle to terminate.

How the read terminates decides the outcome:

- **Bus error.** The block raises a one-cycle request for illegal-instruction exception processing.
- **Acknowledge.** The block captures the returned word and hands it to the pipeline as a replacement opcode, with a one-cycle strobe.
- **No termination.** A debugger that never answers cannot hang the core. A watchdog forces the exception path after a fixed number of wait cycles.

Because the answer comes from an external bus cycle, the mechanism does not depend on where the exception vectors are located.

Top module: `bkpt_ack_ctrl`

## Requirements
- R1: After reset, `dec_stall`, `bus_req`, `bus_addr`, `bus_fc`, `inj_valid`, `inj_opcode` and `exc_req` are all zero.
- R2: An opcode is a breakpoint only when its upper 13 bits equal those of 16'h4848, i.e. values 16'h4848 to 16'h484F. Any other opcode presented with `dec_valid` high starts no bus cycle and raises no stall.
- R3: After a breakpoint is accepted, `bus_req` rises on the next cycle and stays high until a termination is taken. While it is high, `bus_fc` is 3'b111. While it is high, `bus_addr` holds the breakpoint number (opcode bits 2:0) in bits 4:2, and every other address bit is zero.
- R4: A bus error sampled while the block is waiting for termination gives exactly one cycle of `exc_req` on the next cycle. No `inj_valid` is raised.
- R5: An acknowledge sampled while the block is waiting gives exactly one cycle of `inj_valid` on the next cycle. In that cycle, `inj_opcode` equals the `bus_rdata` sampled with the acknowledge. At all other times `inj_opcode` is zero.
- R6: When bus error and acknowledge are sampled in the same cycle, the bus error wins and the exception path is taken.
- R7: If 256 consecutive waiting cycles pass without a termination, the block takes the exception path. A termination sampled in the 256th waiting cycle is still honoured.
- R8: `dec_stall` is high from the cycle in which a breakpoint is presented until the cycle after `inj_valid` or `exc_req`, when the block returns to idle.
- R9: An opcode presented with `dec_subst` high is never treated as a breakpoint, even if it lies in the breakpoint range.
- R10: While the block is idle, acknowledge and bus error have no effect. While it is busy, new decode input does not change the bus address or the outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode presents an opcode |
| dec_opcode | input | 16 | Opcode from decode |
| dec_subst | input | 1 | Opcode is a substituted replacement |
| dec_stall | output | 1 | Hold decode |
| bus_req | output | 1 | Breakpoint read cycle in progress |
| bus_addr | output | 32 | Read address, breakpoint number in bits 4:2 |
| bus_fc | output | 3 | Address-space code, 3'b111 during the cycle |
| bus_rdata | input | 16 | Read data from the bus |
| bus_ack | input | 1 | Normal data acknowledge |
| bus_berr | input | 1 | Bus error termination |
| inj_valid | output | 1 | Replacement opcode strobe |
| inj_opcode | output | 16 | Replacement opcode |
| exc_req | output | 1 | Illegal-instruction exception request |

## Verification
The hardest situation to reach from the ports is the timeout edge. Reaching it needs 256 silent waiting cycles, and a termination arriving in the last waiting cycle must still be honoured instead of the forced exception. Directed transactions hold the bus silent for exactly 255 cycles and then either stay silent one more cycle or acknowledge in that final cycle, so both sides of the boundary are observed. The ordinary paths are covered by randomized transactions with random breakpoint numbers, wait lengths, termination kinds (including simultaneous termination) and read data.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int OP_W  = 16;
    localparam int NUM_W = 3;
    localparam int FC_W  = 3;

    localparam logic [OP_W-1:0] BKPT_BASE = 16'h4848;
    localparam logic [OP_W-1:0] BKPT_MASK = 16'hFFF8;
    localparam logic [FC_W-1:0] FC_CPU    = 3'b111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUS_REQ,
        ST_WAIT_TERM,
        ST_INJECT,
        ST_EXCEPT
    } bk_state_e;

    typedef struct packed {
        logic             hit;
        logic [NUM_W-1:0] num;
    } bk_hit_t;

    typedef struct packed {
        logic berr;
        logic ack;
    } bk_term_t;

    function automatic logic is_bkpt(input logic [OP_W-1:0] op);
        return (op & BKPT_MASK) == BKPT_BASE;
    endfunction

endpackage

// File: rtl/bkpt_decode.sv
module bkpt_decode
    import bkpt_pkg::*;
(
    input  logic            valid,
    input  logic            subst,
    input  logic [OP_W-1:0] opcode,
    output bk_hit_t         hit
);
    always_comb begin
        hit.hit = valid && !subst && is_bkpt(opcode);
        hit.num = opcode[NUM_W-1:0];
    end
endmodule

// File: rtl/bkpt_timeout.sv
module bkpt_timeout #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign expired = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bkpt_seq.sv
module bkpt_seq
    import bkpt_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  bk_hit_t          hit,
    input  bk_term_t         term,
    input  logic [DW-1:0]    rdata,
    input  logic             expired,
    output bk_state_e        state,
    output logic [NUM_W-1:0] num_q,
    output logic [DW-1:0]    data_q
);
    bk_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (hit.hit) nxt = ST_BUS_REQ;
            ST_BUS_REQ:   nxt = ST_WAIT_TERM;
            ST_WAIT_TERM: begin
                if (term.berr)     nxt = ST_EXCEPT;
                else if (term.ack) nxt = ST_INJECT;
                else if (expired)  nxt = ST_EXCEPT;
            end
            ST_INJECT:    nxt = ST_IDLE;
            ST_EXCEPT:    nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            num_q  <= '0;
            data_q <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && hit.hit) begin
                num_q <= hit.num;
            end
            if (state == ST_WAIT_TERM && !term.berr && term.ack) begin
                data_q <= rdata;
            end
        end
    end
endmodule

// File: rtl/bkpt_ack_ctrl.sv
module bkpt_ack_ctrl
    import bkpt_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 16,
    parameter int TIMEOUT = 256,
    parameter int NUM_LSB = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dec_valid,
    input  logic [15:0]   dec_opcode,
    input  logic          dec_subst,
    output logic          dec_stall,
    output logic          bus_req,
    output logic [AW-1:0] bus_addr,
    output logic [2:0]    bus_fc,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack,
    input  logic          bus_berr,
    output logic          inj_valid,
    output logic [DW-1:0] inj_opcode,
    output logic          exc_req
);
    localparam int NUM_MSB = NUM_LSB + NUM_W - 1;

    bk_hit_t          hit;
    bk_term_t         term;
    bk_state_e        state;
    logic [NUM_W-1:0] num_q;
    logic [DW-1:0]    data_q;
    logic             expired;
    logic             waiting;

    assign term.berr = bus_berr;
    assign term.ack  = bus_ack;
    assign waiting   = (state == ST_WAIT_TERM);

    bkpt_decode u_dec (
        .valid  (dec_valid),
        .subst  (dec_subst),
        .opcode (dec_opcode),
        .hit    (hit)
    );

    bkpt_timeout #(.LIMIT(TIMEOUT)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .run     (waiting),
        .expired (expired)
    );

    bkpt_seq #(.DW(DW)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .term    (term),
        .rdata   (bus_rdata),
        .expired (expired),
        .state   (state),
        .num_q   (num_q),
        .data_q  (data_q)
    );

    assign bus_req = (state == ST_BUS_REQ) || waiting;
    assign bus_fc  = bus_req ? FC_CPU : '0;

    for (genvar i = 0; i < AW; i++) begin : g_addr
        if (i >= NUM_LSB && i <= NUM_MSB) begin : g_num
            assign bus_addr[i] = bus_req & num_q[i - NUM_LSB];
        end else begin : g_zero
            assign bus_addr[i] = 1'b0;
        end
    end

    assign inj_valid  = (state == ST_INJECT);
    assign inj_opcode = inj_valid ? data_q : '0;
    assign exc_req    = (state == ST_EXCEPT);
    assign dec_stall  = (state != ST_IDLE) || hit.hit;
endmodule

// File: rtl/bkpt_ack_checker.sv
module bkpt_ack_checker #(
    parameter int AW      = 32,
    parameter int DW      = 16,
    parameter int TIMEOUT = 256
) (
    input logic          clk,
    input logic          rst,
    input logic          dec_stall,
    input logic          bus_req,
    input logic [AW-1:0] bus_addr,
    input logic [2:0]    bus_fc,
    input logic          bus_ack,
    input logic          bus_berr,
    input logic          inj_valid,
    input logic [DW-1:0] inj_opcode,
    input logic          exc_req
);
    logic [15:0] req_run;

    always_ff @(posedge clk) begin
        if (rst || !bus_req) req_run <= '0;
        else if (req_run != 16'hFFFF) req_run <= req_run + 1'b1;
    end

    a_r3_fc_cpu: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> bus_fc == 3'b111);

    a_r3_addr_held: assert property (@(posedge clk) disable iff (rst)
        (bus_req && $past(bus_req)) |-> $stable(bus_addr));

    a_r4_exc_pulse: assert property (@(posedge clk) disable iff (rst)
        exc_req |=> !exc_req);

    a_r5_inj_pulse: assert property (@(posedge clk) disable iff (rst)
        inj_valid |=> !inj_valid);

    a_r5_opcode_zero: assert property (@(posedge clk) disable iff (rst)
        !inj_valid |-> inj_opcode == '0);

    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(exc_req && inj_valid));

    a_r6_berr_wins: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_berr) |=> !inj_valid);

    a_r8_stall_busy: assert property (@(posedge clk) disable iff (rst)
        (bus_req || inj_valid || exc_req) |-> dec_stall);

    a_r7_bounded_wait: assert property (@(posedge clk) disable iff (rst)
        req_run <= 16'(TIMEOUT + 1));
endmodule

bind bkpt_ack_ctrl bkpt_ack_checker #(.AW(AW), .DW(DW), .TIMEOUT(TIMEOUT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dec_stall  (dec_stall),
    .bus_req    (bus_req),
    .bus_addr   (bus_addr),
    .bus_fc     (bus_fc),
    .bus_ack    (bus_ack),
    .bus_berr   (bus_berr),
    .inj_valid  (inj_valid),
    .inj_opcode (inj_opcode),
    .exc_req    (exc_req)
);

// File: tb/bkpt_ack_ctrl_test.sv
`timescale 1ns/1ps
module bkpt_ack_ctrl_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        dec_valid, dec_subst, dec_stall;
    logic [15:0] dec_opcode;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic [2:0]  bus_fc;
    logic [15:0] bus_rdata;
    logic        bus_ack, bus_berr;
    logic        inj_valid;
    logic [15:0] inj_opcode;
    logic        exc_req;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    bkpt_ack_ctrl uut (
        .clk(clk), .rst(rst),
        .dec_valid(dec_valid), .dec_opcode(dec_opcode), .dec_subst(dec_subst),
        .dec_stall(dec_stall), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_fc(bus_fc), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .bus_berr(bus_berr), .inj_valid(inj_valid), .inj_opcode(inj_opcode),
        .exc_req(exc_req)
    );

    function automatic logic [31:0] exp_addr(input logic [2:0] num);
        return {27'd0, num, 2'b00};
    endfunction

    function automatic logic in_range(input logic [15:0] op);
        return op[15:3] == 13'h0909;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            finish_run();
        end
    end

    task automatic check_idle(input string req);
        chk(req, {31'd0, dec_stall}, 0);
        chk(req, {31'd0, bus_req}, 0);
        chk(req, {29'd0, bus_fc}, 0);
        chk(req, {31'd0, inj_valid}, 0);
        chk(req, {31'd0, exc_req}, 0);
    endtask

    // term: 0 ack, 1 berr, 2 both; precondition: at a falling edge, idle
    task automatic run_txn(input logic [2:0] num, input int delay,
                           input int term, input logic [15:0] rdata);
        dec_valid  = 1'b1;
        dec_opcode = 16'h4848 | {13'd0, num};
        #1;
        chk("R8 stall on detect", {31'd0, dec_stall}, 1);
        @(negedge clk);
        dec_valid = 1'b0;
        chk("R3 bus_req", {31'd0, bus_req}, 1);
        chk("R3 address", bus_addr, exp_addr(num));
        chk("R3 fc", {29'd0, bus_fc}, 32'd7);
        @(negedge clk);
        for (int i = 0; i < delay; i++) begin
            chk("R3 held while waiting", {31'd0, bus_req}, 1);
            @(negedge clk);
        end
        bus_rdata = rdata;
        bus_ack   = (term != 1);
        bus_berr  = (term != 0);
        @(negedge clk);
        bus_ack  = 1'b0;
        bus_berr = 1'b0;
        bus_rdata = 16'hDEAD;
        chk("R3 req dropped", {31'd0, bus_req}, 0);
        chk("R8 stall in result", {31'd0, dec_stall}, 1);
        if (term == 0) begin
            chk("R5 inj_valid", {31'd0, inj_valid}, 1);
            chk("R5 inj_opcode", {16'd0, inj_opcode}, {16'd0, rdata});
            chk("R5 no exc", {31'd0, exc_req}, 0);
        end else begin
            chk(term == 2 ? "R6 berr wins" : "R4 exc_req", {31'd0, exc_req}, 1);
            chk("R4 no inj", {31'd0, inj_valid}, 0);
        end
        @(negedge clk);
        check_idle("R8 back to idle");
        chk("R5 opcode zero after", {16'd0, inj_opcode}, 0);
    endtask

    initial begin
        logic [15:0] op;
        void'($urandom(32'd20240611));
        rst = 1'b1;
        dec_valid = 0; dec_subst = 0; dec_opcode = 0;
        bus_rdata = 0; bus_ack = 0; bus_berr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_idle("R1 reset");
        chk("R1 addr", bus_addr, 0);
        chk("R1 inj_opcode", {16'd0, inj_opcode}, 0);

        // R2 boundary opcodes outside the range
        foreach (op_list[k]) begin
            dec_valid = 1; dec_opcode = op_list[k];
            #1;
            chk("R2 non-breakpoint stall", {31'd0, dec_stall}, 0);
            @(negedge clk);
            chk("R2 non-breakpoint bus", {31'd0, bus_req}, 0);
        end
        dec_valid = 0;

        // R9 substituted opcode in range
        dec_valid = 1; dec_subst = 1; dec_opcode = 16'h4849;
        #1;
        chk("R9 subst stall", {31'd0, dec_stall}, 0);
        @(negedge clk);
        chk("R9 subst bus", {31'd0, bus_req}, 0);
        dec_valid = 0; dec_subst = 0;

        // R10 termination while idle
        bus_ack = 1; bus_berr = 1; bus_rdata = 16'h1234;
        @(negedge clk);
        bus_ack = 0; bus_berr = 0;
        check_idle("R10 idle termination");
        @(negedge clk);
        check_idle("R10 idle termination later");

        // directed boundary numbers
        run_txn(3'd0, 0, 0, 16'h4E71);
        run_txn(3'd7, 2, 1, 16'h0000);
        run_txn(3'd5, 1, 2, 16'hFFFF);

        // R10 new decode while busy
        dec_valid = 1; dec_opcode = 16'h484A;
        @(negedge clk);
        dec_opcode = 16'h484F;
        @(negedge clk);
        chk("R10 addr kept", bus_addr, exp_addr(3'd2));
        @(negedge clk);
        chk("R10 addr kept later", bus_addr, exp_addr(3'd2));
        dec_valid = 0;
        bus_ack = 1; bus_rdata = 16'hA5A5;
        @(negedge clk);
        bus_ack = 0;
        chk("R10 busy result", {16'd0, inj_opcode}, 32'h0000A5A5);
        @(negedge clk);

        // R7 timeout: silent for all waiting cycles
        dec_valid = 1; dec_opcode = 16'h484B;
        @(negedge clk);
        dec_valid = 0;
        @(negedge clk);
        repeat (255) @(negedge clk);
        chk("R7 still waiting at 255", {31'd0, bus_req}, 1);
        chk("R7 no early exc", {31'd0, exc_req}, 0);
        @(negedge clk);
        chk("R7 timeout exc", {31'd0, exc_req}, 1);
        chk("R7 timeout no inj", {31'd0, inj_valid}, 0);
        @(negedge clk);
        check_idle("R7 idle after timeout");

        // R7 acknowledge in the last waiting cycle
        run_txn(3'd6, 255, 0, 16'h7A7A);

        // randomized transactions
        for (int t = 0; t < 40; t++) begin
            logic [2:0] n;
            n = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0) begin
                op = 16'($urandom());
                dec_valid = 1; dec_opcode = op;
                #1;
                chk("R2 random opcode", {31'd0, dec_stall}, {31'd0, in_range(op)});
                dec_valid = 0;
                if (in_range(op)) begin
                    @(negedge clk);
                    @(negedge clk);
                    bus_berr = 1;
                    @(negedge clk);
                    bus_berr = 0;
                    chk("R4 random berr", {31'd0, exc_req}, 1);
                end
                @(negedge clk);
            end
            run_txn(n, $urandom_range(0, 12), $urandom_range(0, 2), 16'($urandom()));
        end
        finish_run();
    end

    logic [15:0] op_list [4] = '{16'h4847, 16'h4850, 16'h4C48, 16'h0848};
endmodule